// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator

This block is the alarm section of a real-time clock. It keeps four alarm bytes (seconds, minutes, hours and day of month), each written in BCD, with bit 7 of each byte acting as a "don't care" flag for that field. It receives the current time fields from the timekeeping core, along with a one-cycle pulse once per second. On each such pulse it decides whether the alarm is due, and if so it produces a single-cycle interrupt pulse.

The set of mask flags that are raised selects how often the alarm repeats. With no flags it fires once a month on the full date and time. Masking the day gives a daily alarm. Masking the day and hour gives an hourly alarm. Masking day, hour and minute gives an alarm once a minute. Every other flag combination fires on every second pulse. Writes are range-checked field by field, and out-of-range values are dropped silently. Every accepted byte reads back unchanged.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset all four alarm bytes read 0x00 and `alarm_irq` is low.
- R2: Field select codes on `wr_sel` and `rd_sel` are 0 for seconds, 1 for minutes, 2 for hours and 3 for day of month. For the seconds and minutes bytes, a write is accepted only if bits 6:0, taken as BCD (bits 6:4 tens, bits 3:0 units, so tens*10+units), are 0 to 59. A rejected write leaves the byte unchanged.
- R3: A write to the hours byte is accepted only if bits 5:0 taken as BCD are 0 to 23. Bits 7:6 are not part of the check.
- R4: A write to the day byte is accepted only if bits 5:0 taken as BCD are nonzero. This includes a write whose only set bit is the mask flag, which is rejected.
- R5: `rd_data` returns, combinationally, the full byte last accepted for the selected field, including bit 7 and any other bits outside the checked range.
- R6: With no mask flag (bit 7) set on any byte, the alarm fires on a second pulse only when seconds (bits 6:0), minutes (6:0), hours (5:0) and day (5:0) all equal the current time fields.
- R7: With only the day flag set, day is ignored and seconds, minutes and hours must match.
- R8: With the day and hour flags set (seconds and minutes flags clear), only seconds and minutes must match.
- R9: With the day, hour and minute flags set (seconds flag clear), only seconds must match.
- R10: Any other flag combination fires on every second pulse.
- R11: `alarm_irq` is high for exactly the one clock cycle after the edge at which `tick` was sampled high with the alarm due. It is never high in response to anything other than a tick.
- R12: An alarm write that is accepted in the same cycle as a tick cancels that tick's evaluation. A rejected write does not cancel it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| wr_en | input | 1 | Alarm byte write strobe |
| wr_sel | input | 2 | Field to write (0 sec, 1 min, 2 hour, 3 day) |
| wr_data | input | 8 | Byte to write |
| rd_sel | input | 2 | Field to read |
| rd_data | output | 8 | Selected alarm byte |
| alarm_irq | output | 1 | One-cycle alarm pulse |

## Verification
The hardest case to reach is a write that lands in the same cycle as a second pulse. The bench drives both strobes on the same falling edge, once with a value that is accepted and once with a value that is rejected, so that cancellation can be told apart from a plain miss. The repeat modes are told apart by presenting time fields that disagree in exactly the field each mode should ignore, and then in the field it still compares. Patterns outside the four named ones, such as only the seconds flag set, are driven with every field wrong.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned AF_NUM = 4;
  localparam int unsigned AF_W   = 8;
  localparam int unsigned AF_SELW = $clog2(AF_NUM);
  localparam int unsigned AF_FLAG = AF_W - 1;

  typedef enum logic [1:0] {
    AF_SEC  = 2'd0,
    AF_MIN  = 2'd1,
    AF_HOUR = 2'd2,
    AF_DATE = 2'd3
  } af_field_e;

  typedef enum logic [2:0] {
    RP_MONTH,
    RP_DAY,
    RP_HOUR,
    RP_MINUTE,
    RP_SECOND
  } rp_mode_e;

  // bits that carry the BCD value of each field
  function automatic logic [AF_W-1:0] field_keep(af_field_e f);
    case (f)
      AF_SEC, AF_MIN: return 8'h7F;
      default:        return 8'h3F;
    endcase
  endfunction

  function automatic logic [7:0] bcd_value(logic [7:0] v);
    logic [7:0] hi;
    logic [7:0] lo;
    hi = {4'd0, v[7:4]};
    lo = {4'd0, v[3:0]};
    return hi * 8'd10 + lo;
  endfunction

  function automatic logic field_accepts(af_field_e f, logic [AF_W-1:0] v);
    logic [7:0] n;
    n = bcd_value(v & field_keep(f));
    case (f)
      AF_SEC, AF_MIN: return n <= 8'd59;
      AF_HOUR:        return n <= 8'd23;
      default:        return n != 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AF_SELW-1:0]          wr_sel,
  input  logic [AF_W-1:0]             wr_data,
  output logic [AF_NUM-1:0][AF_W-1:0] regs,
  output logic                        wr_accepted
);
  logic [AF_NUM-1:0] hit;
  logic [AF_NUM-1:0] ok;

  for (genvar i = 0; i < AF_NUM; i++) begin : g_field
    assign hit[i] = wr_en && (wr_sel == AF_SELW'(i));
    assign ok[i]  = field_accepts(af_field_e'(i), wr_data);

    always_ff @(posedge clk) begin
      if (!rst_n)               regs[i] <= '0;
      else if (hit[i] && ok[i]) regs[i] <= wr_data;
    end

    // R2 R3 R4: an out-of-range write leaves the byte alone
    p_reject_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && !ok[i]) |=> $stable(regs[i]));

    // R5: an accepted byte is stored whole
    p_store_whole_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && ok[i]) |=> (regs[i] == $past(wr_data)));
  end

  assign wr_accepted = |(hit & ok);
endmodule

// File: rtl/rtc_alarm_mode.sv
module rtc_alarm_mode
  import rtc_alarm_pkg::*;
(
  input  logic [AF_NUM-1:0] masks,
  output logic [AF_NUM-1:0] cmp_en
);
  rp_mode_e mode;

  always_comb begin
    case (masks)
      4'b0000: mode = RP_MONTH;
      4'b1000: mode = RP_DAY;
      4'b1100: mode = RP_HOUR;
      4'b1110: mode = RP_MINUTE;
      default: mode = RP_SECOND;
    endcase
  end

  always_comb begin
    case (mode)
      RP_MONTH:  cmp_en = 4'b1111;
      RP_DAY:    cmp_en = 4'b0111;
      RP_HOUR:   cmp_en = 4'b0011;
      RP_MINUTE: cmp_en = 4'b0001;
      default:   cmp_en = 4'b0000;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic                        rearm,
  input  logic [AF_NUM-1:0][AF_W-1:0] regs,
  input  logic [AF_NUM-1:0][AF_W-1:0] now,
  input  logic [AF_NUM-1:0]           cmp_en,
  output logic                        irq
);
  logic [AF_NUM-1:0] field_eq;
  logic              all_match;
  logic              fire;

  for (genvar i = 0; i < AF_NUM; i++) begin : g_cmp
    assign field_eq[i] = !cmp_en[i] ||
      (((regs[i] ^ now[i]) & field_keep(af_field_e'(i))) == '0);
  end

  assign all_match = &field_eq;
  assign fire      = tick && all_match && !rearm;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fire;
  end

  // R11: the pulse only follows a tick
  p_irq_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick));

  // R12: an accepted write on the tick cycle cancels that evaluation
  p_rearm_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rearm) |=> !irq);

  // R10: with nothing compared every tick fires unless rearmed
  p_every_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rearm && cmp_en == '0) |=> irq);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_date,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data,
  output logic       alarm_irq
);
  logic [AF_NUM-1:0][AF_W-1:0] regs;
  logic [AF_NUM-1:0][AF_W-1:0] now;
  logic [AF_NUM-1:0]           masks;
  logic [AF_NUM-1:0]           cmp_en;
  logic                        wr_accepted;

  assign now = {now_date, now_hour, now_min, now_sec};

  for (genvar i = 0; i < AF_NUM; i++) begin : g_mask
    assign masks[i] = regs[i][AF_FLAG];
  end

  rtc_alarm_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .regs        (regs),
    .wr_accepted (wr_accepted)
  );

  rtc_alarm_mode u_mode (
    .masks  (masks),
    .cmp_en (cmp_en)
  );

  rtc_alarm_match u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .rearm  (wr_accepted),
    .regs   (regs),
    .now    (now),
    .cmp_en (cmp_en),
    .irq    (alarm_irq)
  );

  assign rd_data = regs[rd_sel];

  // R1: quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !alarm_irq);
endmodule

// File: tb/sim_rtc_alarm_unit.sv
module sim_rtc_alarm_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       alarm_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rtc_alarm_unit u0 (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] sel, logic [7:0] exp);
    rd_sel = sel;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic set_all(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d);
    wr(2'd0, s); wr(2'd1, m); wr(2'd2, h); wr(2'd3, d);
  endtask

  // one tick with given time; irq must equal exp then drop
  task automatic tick_chk(string req, logic [7:0] s, logic [7:0] m,
                          logic [7:0] h, logic [7:0] d, logic exp);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_date = d; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(req, {7'd0, alarm_irq}, {7'd0, exp});
    @(negedge clk);
    chk({req, " pulse ends"}, {7'd0, alarm_irq}, 8'd0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) rd_chk("R1 reset byte", 2'(i), 8'h00);
    chk("R1 irq low", {7'd0, alarm_irq}, 8'd0);
  endtask

  task automatic t_ranges;
    wr(2'd0, 8'h59); rd_chk("R2 sec 59 ok", 2'd0, 8'h59);
    wr(2'd0, 8'h60); rd_chk("R2 sec 60 rejected", 2'd0, 8'h59);
    wr(2'd0, 8'h5A); rd_chk("R2 sec 5A rejected", 2'd0, 8'h59);
    wr(2'd1, 8'h00); rd_chk("R2 min 00 ok", 2'd1, 8'h00);
    wr(2'd1, 8'h7F); rd_chk("R2 min 7F rejected", 2'd1, 8'h00);
    wr(2'd2, 8'h23); rd_chk("R3 hour 23 ok", 2'd2, 8'h23);
    wr(2'd2, 8'h24); rd_chk("R3 hour 24 rejected", 2'd2, 8'h23);
    wr(2'd2, 8'h63); rd_chk("R5 hour 63 stored whole", 2'd2, 8'h63);
    wr(2'd3, 8'h31); rd_chk("R4 date 31 ok", 2'd3, 8'h31);
    wr(2'd3, 8'h00); rd_chk("R4 date 00 rejected", 2'd3, 8'h31);
    wr(2'd3, 8'h80); rd_chk("R4 date 80 rejected", 2'd3, 8'h31);
    wr(2'd0, 8'hC5); rd_chk("R5 sec flag kept", 2'd0, 8'hC5);
  endtask

  task automatic t_modes;
    set_all(8'h30, 8'h15, 8'h08, 8'h12);
    tick_chk("R6 monthly all match", 8'h30, 8'h15, 8'h08, 8'h12, 1'b1);
    tick_chk("R6 monthly date off", 8'h30, 8'h15, 8'h08, 8'h13, 1'b0);
    wr(2'd3, 8'h92);
    tick_chk("R7 daily date ignored", 8'h30, 8'h15, 8'h08, 8'h05, 1'b1);
    tick_chk("R7 daily hour off", 8'h30, 8'h15, 8'h09, 8'h12, 1'b0);
    wr(2'd2, 8'h88);
    tick_chk("R8 hourly hour ignored", 8'h30, 8'h15, 8'h21, 8'h05, 1'b1);
    tick_chk("R8 hourly min off", 8'h30, 8'h16, 8'h08, 8'h12, 1'b0);
    wr(2'd1, 8'h95);
    tick_chk("R9 minute min ignored", 8'h30, 8'h44, 8'h21, 8'h05, 1'b1);
    tick_chk("R9 minute sec off", 8'h31, 8'h15, 8'h08, 8'h12, 1'b0);
    set_all(8'hB0, 8'h15, 8'h08, 8'h12);
    tick_chk("R10 sec-only flag fires", 8'h01, 8'h02, 8'h03, 8'h04, 1'b1);
  endtask

  task automatic t_no_tick;
    @(negedge clk);
    now_sec = 8'h30;
    repeat (3) @(negedge clk);
    chk("R11 no tick no irq", {7'd0, alarm_irq}, 8'd0);
  endtask

  task automatic t_rearm;
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h20;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R12 accepted write cancels tick", {7'd0, alarm_irq}, 8'd0);
    rd_chk("R12 write landed", 2'd1, 8'h20);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h61;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R12 rejected write no cancel", {7'd0, alarm_irq}, 8'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ranges();
    t_modes();
    t_no_tick();
    t_rearm();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule